// File: doc/BRIEF.md
# Horizontal Microcode Sequencer

This block steps through a wide microprogram held in a control store that is fixed when the block is elaborated. Each microinstruction word drives the control-output bus directly. Every word also names its own successor, so the sequencer has no program-counter incrementer: the next address is always the word's next-address field. Some or all of that field's low bits may be replaced by condition inputs or by a loop-counter test. A small down-counter next to the sequencer handles repeat-N and wait-N loops, so a long wait needs one word rather than N states.

A word can take one of four branch modes. Unconditional jump. One-way test: one condition bit replaces address bit 0. Four-way dispatch: two condition bits replace address bits 1:0. Loop test: the counter-zero flag replaces bit 0. A word may also load the counter, and a word with its halt bit set stops the sequencer until reset.

The next address goes into a register, so a branch decision shows one cycle after the word that made it. The sequencer has two states, named `SQ_RUN` and `SQ_HALT`. The transition `SQ_RUN -> SQ_HALT` happens when the current word has its halt bit set. `SQ_HALT` is left only through reset, which returns the sequencer to `SQ_RUN`.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a rising edge, the sequencer goes to address 0, the loop counter is cleared and `halted_o` is driven low. After that edge, `ctl_o` shows the control field of word 0.
- R2: A word whose branch-select field is 0 (jump) makes the next address exactly its next-address field, whatever `cond_i` holds.
- R3: A word whose branch-select field is 1 (one-way test) makes the next address equal to its next-address field with bit 0 replaced by `cond_i[csel]`. Here `csel` is the word's 2-bit condition-select field.
- R4: A word whose branch-select field is 2 (four-way dispatch) makes the next address equal to its next-address field with bit 1 replaced by `cond_i[(csel+1) mod 4]` and bit 0 replaced by `cond_i[csel]`.
- R5: A word whose branch-select field is 3 (loop test) makes the next address equal to its next-address field with bit 0 replaced by 1 when the counter is zero and by 0 otherwise. If the counter is nonzero and the word does not load it, the counter decreases by one.
- R6: A word with its counter-load bit set writes its 4-bit load value into the counter at the end of its cycle. When the same word is also a loop test, the load wins over the decrement, and the branch still uses the counter value from before the load.
- R7: `cond_i` is sampled only at the rising edge that ends the word doing the test. Its value in any other cycle has no effect on the path taken.
- R8: A word with its halt bit set keeps the address and the counter unchanged. `halted_o` rises one cycle later and stays high until reset, and while halted `ctl_o` holds steady whatever `cond_i` does.
- R9: `ctl_o` is the 8-bit control field of the word at the current address, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 4 | Condition inputs used by the test and dispatch modes |
| ctl_o | output | 8 | Control field of the current microinstruction |
| halted_o | output | 1 | High once a halt word has stopped the sequencer |

## Verification
Two functions can fall in the same cycle here: a counter load and a loop-test decrement, when a single word both loads the counter and tests it. The bench's program has such a word. It is reached with the counter at 1, and the bench then follows the loop tests that come after it. If the load wins, the path goes through addresses 24, 26 and 28. If the decrement wins instead, the counter reaches zero early and the next word branches to 25, which shows up on `ctl_o` at once. The halt word is also tested against a changing `cond_i` in the same cycle, and the check is that `ctl_o` stays frozen.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ADDR_W = 5;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int CTL_W  = 8;
    localparam int CNT_W  = 4;
    localparam int COND_W = 4;
    localparam int CSEL_W = $clog2(COND_W);

    typedef enum logic [1:0] {
        BR_JUMP  = 2'd0,
        BR_TEST1 = 2'd1,
        BR_TEST2 = 2'd2,
        BR_LOOP  = 2'd3
    } br_sel_e;

    typedef enum logic {
        SQ_RUN  = 1'b0,
        SQ_HALT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic              halt;
        logic              ld;
        logic [CNT_W-1:0]  ldval;
        br_sel_e           bsel;
        logic [CSEL_W-1:0] csel;
        logic [ADDR_W-1:0] nxt;
        logic [CTL_W-1:0]  ctl;
    } uinst_t;

    typedef uinst_t [DEPTH-1:0] ustore_t;

    // Default image: a straight chain that halts on the last word.
    function automatic ustore_t default_prog();
        ustore_t p;
        for (int i = 0; i < DEPTH; i++) begin
            p[i]       = '0;
            p[i].ctl   = CTL_W'(i);
            p[i].nxt   = ADDR_W'((i + 1) % DEPTH);
            p[i].bsel  = BR_JUMP;
            p[i].halt  = (i == DEPTH - 1);
        end
        return p;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter ustore_t PROG = default_prog()
) (
    input  logic [ADDR_W-1:0] addr,
    output uinst_t            word
);
    // Asynchronous read of the fixed control store.
    assign word = PROG[addr];
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  br_sel_e           bsel,
    input  logic [CSEL_W-1:0] csel,
    input  logic [ADDR_W-1:0] nxt,
    input  logic [COND_W-1:0] cond,
    input  logic              cnt_zero,
    output logic [ADDR_W-1:0] nxt_addr
);
    logic [CSEL_W-1:0] csel_hi;

    assign csel_hi = csel + CSEL_W'(1);

    always_comb begin
        unique case (bsel)
            BR_JUMP:  nxt_addr = nxt;
            BR_TEST1: nxt_addr = {nxt[ADDR_W-1:1], cond[csel]};
            BR_TEST2: nxt_addr = {nxt[ADDR_W-1:2], cond[csel_hi], cond[csel]};
            BR_LOOP:  nxt_addr = {nxt[ADDR_W-1:1], cnt_zero};
            default:  nxt_addr = nxt;
        endcase
    end
endmodule

// File: rtl/useq_loop.sv
module useq_loop
    import useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             ld,
    input  logic [CNT_W-1:0] ldval,
    input  logic             dec_en,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_zero
);
    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!hold) begin
            if (ld)
                cnt <= ldval;
            else if (dec_en && !cnt_zero)
                cnt <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter ustore_t PROG = default_prog()
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COND_W-1:0] cond_i,
    output logic [CTL_W-1:0]  ctl_o,
    output logic              halted_o
);
    logic [ADDR_W-1:0] upc_q;
    logic [ADDR_W-1:0] nxt_addr;
    uinst_t            word;
    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              cnt_zero;
    logic              freeze;

    useq_store #(.PROG(PROG)) i_store (
        .addr (upc_q),
        .word (word)
    );

    useq_next i_next (
        .bsel     (word.bsel),
        .csel     (word.csel),
        .nxt      (word.nxt),
        .cond     (cond_i),
        .cnt_zero (cnt_zero),
        .nxt_addr (nxt_addr)
    );

    assign freeze = word.halt || (state_q == SQ_HALT);

    useq_loop i_loop (
        .clk      (clk),
        .rst      (rst),
        .hold     (freeze),
        .ld       (word.ld),
        .ldval    (word.ldval),
        .dec_en   (word.bsel == BR_LOOP),
        .cnt      (cnt_q),
        .cnt_zero (cnt_zero)
    );

    // Microprogram address register: no incrementer, next address from the word.
    always_ff @(posedge clk) begin
        if (rst)
            upc_q <= '0;
        else if (!freeze)
            upc_q <= nxt_addr;
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_RUN;
        end else begin
            unique case (state_q)
                SQ_RUN:  if (word.halt) state_q <= SQ_HALT;
                SQ_HALT: state_q <= SQ_HALT;
                default: state_q <= SQ_RUN;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        ctl_o    = word.ctl;
        halted_o = (state_q == SQ_HALT);
    end
endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] upc,
    input logic [CNT_W-1:0]  cnt,
    input br_sel_e           bsel,
    input logic [ADDR_W-1:0] nxt,
    input logic              halt,
    input logic              ld,
    input logic [CNT_W-1:0]  ldval,
    input logic              halted,
    input logic [CTL_W-1:0]  ctl
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (upc == '0 && cnt == '0 && !halted));

    // R2
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (bsel == BR_JUMP && !halt) |=> upc == $past(nxt));

    // R3
    test1_high_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (bsel == BR_TEST1 && !halt) |=> upc[ADDR_W-1:1] == $past(nxt[ADDR_W-1:1]));

    // R5
    loop_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (bsel == BR_LOOP && !halt && cnt == '0) |=> upc[0]);

    // R5
    loop_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (bsel == BR_LOOP && !halt && !ld && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

    // R6
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ld && !halt) |=> cnt == $past(ldval));

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(upc) && $stable(ctl)));
endmodule

bind useq_top useq_chk i_useq_chk (
    .clk    (clk),
    .rst    (rst),
    .upc    (upc_q),
    .cnt    (cnt_q),
    .bsel   (word.bsel),
    .nxt    (word.nxt),
    .halt   (word.halt),
    .ld     (word.ld),
    .ldval  (word.ldval),
    .halted (halted_o),
    .ctl    (ctl_o)
);

// File: tb/test_useq_top.sv
module test_useq_top;
    import useq_pkg::*;

    function automatic uinst_t mk(input int c, input int n, input br_sel_e b,
                                  input int cs, input bit l, input int lv, input bit h);
        uinst_t w;
        w.ctl   = CTL_W'(c);
        w.nxt   = ADDR_W'(n);
        w.bsel  = b;
        w.csel  = CSEL_W'(cs);
        w.ld    = l;
        w.ldval = CNT_W'(lv);
        w.halt  = h;
        return w;
    endfunction

    function automatic ustore_t build_prog();
        ustore_t p;
        for (int i = 0; i < DEPTH; i++) p[i] = mk(i, 0, BR_JUMP, 0, 0, 0, 0);
        p[0]  = mk(0, 0, BR_LOOP, 0, 0, 0, 0);
        p[1]  = mk(1, 4, BR_TEST1, 0, 0, 0, 0);
        p[4]  = mk(4, 8, BR_JUMP, 0, 0, 0, 0);
        p[5]  = mk(5, 8, BR_JUMP, 0, 0, 0, 0);
        p[8]  = mk(8, 12, BR_TEST2, 1, 0, 0, 0);
        for (int i = 12; i < 16; i++) p[i] = mk(i, 16, BR_JUMP, 0, 0, 0, 0);
        p[16] = mk(16, 18, BR_JUMP, 0, 1, 3, 0);
        p[18] = mk(18, 18, BR_LOOP, 0, 0, 0, 0);
        p[19] = mk(19, 22, BR_JUMP, 0, 1, 1, 0);
        p[22] = mk(22, 24, BR_LOOP, 0, 1, 2, 0);
        p[24] = mk(24, 26, BR_LOOP, 0, 0, 0, 0);
        p[26] = mk(26, 28, BR_LOOP, 0, 0, 0, 0);
        p[28] = mk(28, 28, BR_LOOP, 0, 0, 0, 0);
        p[29] = mk(29, 0, BR_JUMP, 0, 0, 0, 1);
        return p;
    endfunction

    localparam ustore_t TB_PROG = build_prog();
    localparam int NVEC = 17;
    // {expected halted, cond applied, expected ctl}
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 4'b0101, 8'd1},  {1'b0, 4'b0101, 8'd5},  {1'b0, 4'b0000, 8'd8},
        {1'b0, 4'b0101, 8'd14}, {1'b0, 4'b0000, 8'd16}, {1'b0, 4'b0000, 8'd18},
        {1'b0, 4'b1111, 8'd18}, {1'b0, 4'b0000, 8'd18}, {1'b0, 4'b0000, 8'd18},
        {1'b0, 4'b0000, 8'd19}, {1'b0, 4'b0000, 8'd22}, {1'b0, 4'b0000, 8'd24},
        {1'b0, 4'b0000, 8'd26}, {1'b0, 4'b0000, 8'd28}, {1'b0, 4'b0000, 8'd29},
        {1'b1, 4'b1111, 8'd29}, {1'b1, 4'b0001, 8'd29}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [COND_W-1:0] cond_i = '0;
    logic [CTL_W-1:0]  ctl_o;
    logic              halted_o;
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    useq_top #(.PROG(TB_PROG)) i_useq_top (
        .clk      (clk),
        .rst      (rst),
        .cond_i   (cond_i),
        .ctl_o    (ctl_o),
        .halted_o (halted_o)
    );

    function automatic string vec_tag(input int i);
        case (i)
            0, 6, 7, 8, 9, 12, 13, 14: return "R5";
            1:                          return "R3";
            2, 4:                       return "R2";
            3:                          return "R4";
            5, 10, 11:                  return "R6";
            default:                    return "R8";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 ctl", int'(ctl_o), 0);
        check("R1 halted", int'(halted_o), 0);
        rst = 1'b0;
    endtask

    // Drive cond for one cycle, then sample after the edge.
    task automatic step(input logic [COND_W-1:0] c, input string req, input int exp_ctl);
        cond_i = c;
        @(posedge clk);
        @(negedge clk);
        check(req, int'(ctl_o), exp_ctl);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R9 word0", int'(ctl_o), int'(TB_PROG[0].ctl));

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][11:8], vec_tag(i), int'(VEC[i][7:0]));
            check({vec_tag(i), " halted"}, int'(halted_o), int'(VEC[i][12]));
        end

        // R1: reset leaves the halted state
        do_reset();

        // R7: cond high only after the test word's cycle has no effect
        step(4'b0000, "R5 exit", 1);
        step(4'b0000, "R7 late cond", 4);
        step(4'b1111, "R2 cond ignored", 8);
        step(4'b0000, "R4 dispatch 00", 12);

        do_reset();
        step(4'b0000, "R5 exit", 1);
        step(4'b0001, "R3 taken", 5);
        step(4'b0000, "R2", 8);
        step(4'b0010, "R4 dispatch 01", 13);

        do_reset();
        step(4'b0000, "R5 exit", 1);
        step(4'b0000, "R3 not taken", 4);
        step(4'b0000, "R2", 8);
        step(4'b0110, "R4 dispatch 11", 15);
        step(4'b0000, "R2", 16);
        step(4'b0000, "R6 load", 18);
        step(4'b0000, "R5 repeat", 18);
        // R1: reset mid-loop clears the counter; word 0 then exits at once
        do_reset();
        step(4'b0000, "R1 counter cleared", 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule